// File: doc/BRIEF.md
# External Interrupt Polarity Conditioner

The block sits between three external interrupt pins and a downstream interrupt controller that accepts only active-high level requests or rising-edge requests. Each pin is synchronised, sampled and conditioned according to an 8-bit control field for that line. Active-low levels are inverted before they reach the controller. Falling edges become rising requests. In the two edge modes, a detected edge sets a sticky pending flag. The controller's request line then follows that flag, gated by the line enable, until software clears it.

Software reaches the three control fields through a single-cycle register port with byte enables. An elaboration parameter selects one of two register layouts. In the first, all three fields are packed into one 32-bit word at address 0 and byte enables select the field written. In the second, each line has its own register and its field sits in the low byte. A per-line clock-select bit chooses the sampling rate. When set, the line is sampled on every clock. When clear, it is sampled on a slow strobe from a shared prescaler.

Top module: `extirq_conditioner`

## Requirements
- R1: After reset every control field reads 0x00 and all three request outputs are low.
- R2: Within a field, bits 7:6 hold the trigger code, bit 5 the line enable, bit 4 the clock select and bit 0 the pending flag. Bits 3:1 always read zero, and written control bits read back unchanged.
- R3: When SHARED_WORD=1, address 0 holds line 0 in bits 23:16, line 1 in bits 15:8 and line 2 in bits 7:0, with bits 31:24 reading zero. A write changes only the fields whose byte enable is set.
- R4: When SHARED_WORD=0, the fields of lines 0, 1 and 2 sit in bits 7:0 at addresses 0x000, 0x328 and 0x32C. A write needs byte enable 0. Any other address reads zero and ignores writes.
- R5: Trigger code 00 (high level): with the clock select at 1, the request follows the pin, three clock edges after the pin changes.
- R6: Trigger code 01 (low level): the request is the inverted pin, with the same latency as R5.
- R7: Trigger code 10 (rising edge): a 0-to-1 transition on the pin sets the pending flag three clock edges later. The pending flag stays set after the pin returns low.
- R8: Trigger code 11 (falling edge): a 1-to-0 transition sets the pending flag, with the same latency as R7. The request is driven high, so the controller sees a rising request.
- R9: Writing 1 to bit 0 of a field clears that line's pending flag, and writing 0 to it leaves the flag unchanged. If an edge is detected in the same cycle as the clear, the flag ends up set.
- R10: With the enable at 0, the request stays low in every mode. Edges still set the pending flag.
- R11: With the clock select at 0, the line is sampled only once every SLOW_DIV cycles. The request is then due between 3 and SLOW_DIV+2 clock edges after the pin changes.
- R12: In the level modes the pending flag is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 3 | Raw external interrupt pins, asynchronous |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_req | output | 3 | Conditioned active-high requests to the downstream controller |

## Verification
With the clock select at 1, every pin change is due at the request output on the third rising clock edge. The pin passes two synchroniser flops and then the sample/pending register, and the output is combinational from that register. The bench drives each pin change on a falling edge. It checks that the request is still unchanged after two rising edges and has changed after the third. Register writes take effect at the single rising edge inside the write task, and reads are combinational, so a readback is made half a cycle after the write. The slow-sampling case is checked against a window, not a fixed cycle. The bench repeats the slow case at four starting phases and requires at least one latency beyond three cycles.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

   localparam int NUM_LINES = 3;
   localparam int FIELD_W   = 8;
   localparam int WORD_W    = 32;

   // Trigger code: bit 1 selects edge, bit 0 selects inverted polarity
   typedef enum logic [1:0] {
      TRIG_HIGH = 2'b00,
      TRIG_LOW  = 2'b01,
      TRIG_RISE = 2'b10,
      TRIG_FALL = 2'b11
   } trig_e;

   typedef struct packed {
      trig_e trig;
      logic  en;
      logic  fast;
   } ctl_t;

   // Field bit positions
   localparam int B_PEND = 0;
   localparam int B_FAST = 4;
   localparam int B_EN   = 5;
   localparam int B_TRIG = 6;

   // Separate-register addresses, one per line
   localparam logic [11:0] LINE_OFS [NUM_LINES] = '{12'h000, 12'h328, 12'h32C};

endpackage

// File: rtl/extirq_sampler.sv
module extirq_sampler
   import extirq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pin,
   input  logic  stb,
   input  trig_e trig,
   output logic  edge_evt,
   output logic  level_act
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   smp_q;
   logic                   now_s;
   logic [1:0]             tcode;

   assign tcode = trig;
   assign now_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         smp_q  <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         if (stb) smp_q <= now_s;
      end
   end

   // Polarity-corrected: an inverted line's inactive-to-active step is a fall
   assign edge_evt  = stb & tcode[1] & (now_s ^ tcode[0]) & ~(smp_q ^ tcode[0]);
   assign level_act = smp_q ^ tcode[0];

endmodule

// File: rtl/extirq_field.sv
module extirq_field
   import extirq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FIELD_W-1:0] wbyte,
   input  logic               edge_evt,
   input  logic               level_act,
   output ctl_t               ctl,
   output logic [FIELD_W-1:0] rd_byte,
   output logic               irq
);

   logic       pend_q;
   logic       clr;
   logic [1:0] tcode;

   assign clr   = wr_en & wbyte[B_PEND];
   assign tcode = ctl.trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= '0;
         pend_q <= 1'b0;
      end else begin
         if (wr_en) begin
            ctl.trig <= trig_e'(wbyte[B_TRIG+:2]);
            ctl.en   <= wbyte[B_EN];
            ctl.fast <= wbyte[B_FAST];
         end
         // a fresh edge outranks a simultaneous clear
         pend_q <= edge_evt | (pend_q & ~clr);
      end
   end

   assign rd_byte = {ctl.trig, ctl.en, ctl.fast, 3'b000, pend_q};
   assign irq     = ctl.en & (tcode[1] ? pend_q : level_act);

   // R7: pending holds unless cleared
   p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr) |=> pend_q);
   // R9: a clear with no competing edge empties the flag
   p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !edge_evt) |=> !pend_q);
   // R12: only a detected edge can raise pending
   p_pend_needs_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !edge_evt) |=> !pend_q);

endmodule

// File: rtl/extirq_regport.sv
module extirq_regport
   import extirq_pkg::*;
#(
   parameter bit SHARED_WORD = 1'b1,
   parameter int ADDR_W      = 12
) (
   input  logic                               wr,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [3:0]                         be,
   input  logic [WORD_W-1:0]                  wdata,
   input  logic [NUM_LINES-1:0][FIELD_W-1:0]  field_rd,
   output logic [NUM_LINES-1:0]               line_wr,
   output logic [NUM_LINES-1:0][FIELD_W-1:0]  line_wbyte,
   output logic [WORD_W-1:0]                  rdata
);

   if (SHARED_WORD) begin : g_shared
      logic hit;
      assign hit = (addr == '0);
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
         localparam int LANE = NUM_LINES - 1 - i;
         assign line_wr[i]    = wr & hit & be[LANE];
         assign line_wbyte[i] = wdata[LANE*FIELD_W +: FIELD_W];
      end
      assign rdata = hit ? {8'h00, field_rd[0], field_rd[1], field_rd[2]} : '0;
   end else begin : g_split
      logic [NUM_LINES-1:0]              hit;
      logic [NUM_LINES-1:0][WORD_W-1:0]  part;
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         assign hit[i]        = (addr == ADDR_W'(LINE_OFS[i]));
         assign line_wr[i]    = wr & be[0] & hit[i];
         assign line_wbyte[i] = wdata[FIELD_W-1:0];
         assign part[i]       = hit[i] ? WORD_W'(field_rd[i]) : '0;
      end
      always_comb begin
         rdata = '0;
         for (int i = 0; i < NUM_LINES; i++) rdata = rdata | part[i];
      end
   end

endmodule

// File: rtl/extirq_conditioner.sv
module extirq_conditioner
   import extirq_pkg::*;
#(
   parameter bit SHARED_WORD = 1'b1,
   parameter int ADDR_W      = 12,
   parameter int SLOW_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] ext_pin,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [3:0]           reg_be,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic [NUM_LINES-1:0] irq_req
);

   localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must reach the highest line register");
   end
   if (SLOW_DIV < 2) begin : g_bad_div
      $error("SLOW_DIV must be at least 2");
   end

   // shared prescaler for slow sampling
   logic [CNT_W-1:0] div_q;
   logic             slow_stb;

   assign slow_stb = (div_q == CNT_W'(SLOW_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (slow_stb) div_q <= '0;
      else               div_q <= div_q + 1'b1;
   end

   logic [NUM_LINES-1:0]              line_wr;
   logic [NUM_LINES-1:0][FIELD_W-1:0] line_wbyte;
   logic [NUM_LINES-1:0][FIELD_W-1:0] field_rd;

   extirq_regport #(
      .SHARED_WORD (SHARED_WORD),
      .ADDR_W      (ADDR_W)
   ) u_regport (
      .wr         (reg_wr),
      .addr       (reg_addr),
      .be         (reg_be),
      .wdata      (reg_wdata),
      .field_rd   (field_rd),
      .line_wr    (line_wr),
      .line_wbyte (line_wbyte),
      .rdata      (reg_rdata)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      ctl_t ctl;
      logic edge_evt;
      logic level_act;
      logic stb;

      assign stb = ctl.fast | slow_stb;

      extirq_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin       (ext_pin[i]),
         .stb       (stb),
         .trig      (ctl.trig),
         .edge_evt  (edge_evt),
         .level_act (level_act)
      );

      extirq_field u_fld (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (line_wr[i]),
         .wbyte     (line_wbyte[i]),
         .edge_evt  (edge_evt),
         .level_act (level_act),
         .ctl       (ctl),
         .rd_byte   (field_rd[i]),
         .irq       (irq_req[i])
      );
   end

   // R11: slow strobe never fires on consecutive cycles
   p_slow_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
      slow_stb |=> !slow_stb);
   // R4: in the split layout at most one field is written per access
   p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !SHARED_WORD |-> $onehot0(line_wr));

endmodule

// File: tb/extirq_conditioner_tb.sv
module extirq_conditioner_tb;

   localparam int CLK_PERIOD = 10;
   localparam int SLOW_DIV   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // index 0: shared-word layout, index 1: split layout
   logic [1:0]       wr = '0;
   logic [1:0][11:0] addr = '0;
   logic [1:0][3:0]  be = '0;
   logic [1:0][31:0] wdata = '0;
   logic [1:0][31:0] rdata;
   logic [1:0][2:0]  pin = '0;
   logic [1:0][2:0]  irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   extirq_conditioner #(.SHARED_WORD(1'b1), .SLOW_DIV(SLOW_DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(pin[0]), .reg_wr(wr[0]),
      .reg_addr(addr[0]), .reg_be(be[0]), .reg_wdata(wdata[0]),
      .reg_rdata(rdata[0]), .irq_req(irq[0]));

   extirq_conditioner #(.SHARED_WORD(1'b0), .SLOW_DIV(SLOW_DIV)) u_dut_sep (
      .clk(clk), .rst_n(rst_n), .ext_pin(pin[1]), .reg_wr(wr[1]),
      .reg_addr(addr[1]), .reg_be(be[1]), .reg_wdata(wdata[1]),
      .reg_rdata(rdata[1]), .irq_req(irq[1]));

   function automatic logic [11:0] line_addr(int ln);
      case (ln)
         0:       return 12'h000;
         1:       return 12'h328;
         default: return 12'h32C;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_line(int m, int ln, logic [7:0] b);
      @(negedge clk);
      wr[m] = 1'b1;
      if (m == 0) begin
         addr[m]  = '0;
         be[m]    = 4'b0001 << (2 - ln);
         wdata[m] = 32'hA5A5A5A5;
         wdata[m][8*(2-ln) +: 8] = b;
      end else begin
         addr[m]  = line_addr(ln);
         be[m]    = 4'b0001;
         wdata[m] = {24'hFFFFFF, b};
      end
      @(negedge clk);
      wr[m] = 1'b0;
      be[m] = '0;
   endtask

   task automatic rd_line(int m, int ln, output logic [7:0] v);
      addr[m] = (m == 0) ? 12'h000 : line_addr(ln);
      #1;
      v = (m == 0) ? rdata[m][8*(2-ln) +: 8] : rdata[m][7:0];
   endtask

   task automatic wait_n(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state on both layouts
      for (int m = 0; m < 2; m++) begin
         for (int ln = 0; ln < 3; ln++) begin
            rd_line(m, ln, v);
            chk("R1 field after reset", 32'(v), 32'h00);
         end
         chk("R1 irq after reset", 32'(irq[m]), 32'h0);
      end
      addr[0] = '0; #1;
      chk("R1/R3 shared word after reset", rdata[0], 32'h0);

      // R2: reserved bits read zero, control bits read back
      for (int m = 0; m < 2; m++) begin
         wr_line(m, 1, 8'hFE);
         rd_line(m, 1, v);
         chk("R2 readback", 32'(v), 32'hF0);
         wr_line(m, 1, 8'h00);
      end

      // R3: shared word packing and byte-enable isolation
      @(negedge clk);
      wr[0] = 1'b1; addr[0] = '0; be[0] = 4'b0010; wdata[0] = 32'hFFFFFFFF;
      @(negedge clk);
      wr[0] = 1'b0; be[0] = '0; #1;
      chk("R3 only line1 lane written", rdata[0], 32'h0000F000);
      @(negedge clk);
      wr[0] = 1'b1; be[0] = 4'b1111; wdata[0] = {8'hFF, 8'h50, 8'h00, 8'hA0};
      @(negedge clk);
      wr[0] = 1'b0; be[0] = '0; #1;
      chk("R3 all lanes, top byte zero", rdata[0], 32'h005000A0);
      wr_line(0, 0, 8'h00);
      wr_line(0, 2, 8'h00);
      addr[0] = '0; #1;
      chk("R3 cleared word", rdata[0], 32'h0);

      // R4: split layout, stray address and missing byte enable ignored
      @(negedge clk);
      wr[1] = 1'b1; addr[1] = 12'h004; be[1] = 4'b1111; wdata[1] = 32'hFFFFFFFF;
      @(negedge clk);
      wr[1] = 1'b0; be[1] = '0; #1;
      chk("R4 stray address reads zero", rdata[1], 32'h0);
      @(negedge clk);
      wr[1] = 1'b1; addr[1] = 12'h328; be[1] = 4'b1110; wdata[1] = 32'hFFFFFFFF;
      @(negedge clk);
      wr[1] = 1'b0; be[1] = '0;
      for (int ln = 0; ln < 3; ln++) begin
         rd_line(1, ln, v);
         chk("R4 fields untouched", 32'(v), 32'h00);
      end
      wr_line(1, 2, 8'h30);
      rd_line(1, 2, v);
      chk("R4 line2 at 0x32C", 32'(v), 32'h30);
      addr[1] = 12'h32C; #1;
      chk("R4 upper bits zero", rdata[1][31:8], 32'h0);
      wr_line(1, 2, 8'h00);

      // R5..R10, R12: sweep of layout x line x trigger x enable, fast sampling
      for (int m = 0; m < 2; m++) begin
         for (int ln = 0; ln < 3; ln++) begin
            for (int t = 0; t < 4; t++) begin
               for (int en = 0; en < 2; en++) begin
                  logic [1:0] tc;
                  logic [7:0] ctlb;
                  logic       idle;
                  string      tag;
                  tc   = 2'(t);
                  idle = tc[0];
                  ctlb = {tc, 1'(en), 1'b1, 4'b0000};
                  case (t)
                     0: tag = "R5";
                     1: tag = "R6";
                     2: tag = "R7";
                     default: tag = "R8";
                  endcase
                  if (en == 0) tag = {tag, "/R10"};
                  pin[m][ln] = idle;
                  wr_line(m, ln, ctlb);
                  wait_n(4);
                  wr_line(m, ln, ctlb | 8'h01);
                  chk({tag, " idle irq"}, 32'(irq[m][ln]), 32'h0);
                  @(negedge clk);
                  pin[m][ln] = ~idle;
                  wait_n(2);
                  chk({tag, " not before 3 edges"}, 32'(irq[m][ln]), 32'h0);
                  wait_n(1);
                  chk({tag, " request on 3rd edge"}, 32'(irq[m][ln]), 32'(en));
                  rd_line(m, ln, v);
                  chk({tag, "/R12 pending flag"}, 32'(v[0]), 32'(tc[1]));
                  pin[m][ln] = idle;
                  wait_n(3);
                  chk({tag, " after pin returns"}, 32'(irq[m][ln]),
                      32'(tc[1] & 1'(en)));
                  if (tc[1]) begin
                     wr_line(m, ln, ctlb);
                     rd_line(m, ln, v);
                     chk("R9 write 0 keeps pending", 32'(v[0]), 32'h1);
                     wr_line(m, ln, ctlb | 8'h01);
                     rd_line(m, ln, v);
                     chk("R9 write 1 clears pending", 32'(v[0]), 32'h0);
                     chk("R9 request drops", 32'(irq[m][ln]), 32'h0);
                  end
                  wr_line(m, ln, 8'h00);
                  pin[m][ln] = 1'b0;
                  wait_n(3);
               end
            end
         end
      end

      // R9: edge in the same cycle as a clear keeps pending set
      wr_line(1, 2, 8'hB0);
      @(negedge clk); pin[1][2] = 1'b1;
      wait_n(4);
      pin[1][2] = 1'b0;
      wait_n(3);
      rd_line(1, 2, v);
      chk("R9 setup pending", 32'(v[0]), 32'h1);
      @(negedge clk);
      pin[1][2] = 1'b1;
      wait_n(2);
      wr[1] = 1'b1; addr[1] = 12'h32C; be[1] = 4'b0001; wdata[1] = 32'h000000B1;
      @(negedge clk);
      wr[1] = 1'b0; be[1] = '0;
      rd_line(1, 2, v);
      chk("R9 set wins over clear", 32'(v[0]), 32'h1);
      chk("R9 request stays high", 32'(irq[1][2]), 32'h1);
      wr_line(1, 2, 8'h01);
      wr_line(1, 2, 8'h00);
      pin[1][2] = 1'b0;
      wait_n(3);

      // R11: slow sampling, four starting phases
      begin
         int max_lat;
         max_lat = 0;
         for (int ph = 0; ph < 4; ph++) begin
            int lat;
            pin[0][0] = 1'b0;
            wr_line(0, 0, 8'hA0);
            wait_n(2 * SLOW_DIV + ph);
            wr_line(0, 0, 8'hA1);
            wait_n(ph);
            pin[0][0] = 1'b1;
            lat = 0;
            while (lat < 12 && irq[0][0] !== 1'b1) begin
               @(negedge clk);
               lat++;
            end
            if (lat > max_lat) max_lat = lat;
            chk("R11 slow latency not under 3", 32'(lat >= 3), 32'h1);
            chk("R11 slow latency within window", 32'(lat <= SLOW_DIV + 2), 32'h1);
            pin[0][0] = 1'b0;
            wait_n(2 * SLOW_DIV);
         end
         chk("R11 slow sampling delays some phase", 32'(max_lat > 3), 32'h1);
         wr_line(0, 0, 8'h01);
      end

      done = 1;
      finish_run();
   end

endmodule